// File: doc/BRIEF.md
# Load/Store Multiple Address Sequencer

This block drives the memory side of a multi-register block transfer. A single start pulse hands it a direction (load or store), an addressing mode, a writeback enable, a word-aligned 32-bit base address and a 16-bit mask of the registers to move. The block then presents one memory beat per selected register on a valid/ready handshake. Each beat carries the register index, the word address and the direction. The memory and the register file sit outside the block and act on each accepted beat.

Registers always go out in ascending index order to ascending word addresses, 4 bytes apart. The mode picks where that address run starts relative to the base: increment or decrement, with the base used before or after the step. Stack-style mode codes (full or empty pointer, stack growing up or down) are translated inside the block into one of the four basic modes. The translation is different for loads and for stores, so a push and the matching pop use the same code. When the last beat has been accepted, a one-cycle done pulse is raised. At the same time the block shows the new base value, which is moved by 4 bytes per register when writeback is on.

Top module: `lsm_addr_seq`

## Requirements
- R1: Each set bit of `rlist_i` gives exactly one beat. The beats come in ascending register index order, and each beat's `beat_load_o` equals the `load_i` that was sampled at start (1 = load, 0 = store).
- R2: Successive beats of one transfer have addresses that rise by exactly 4.
- R3: With `mode_i[2]`=0, bit 1 selects decrement (1) or increment (0), and bit 0 selects before (1) or after (0). Increment-after starts at the base. Increment-before starts at base+4.
- R4: With n registers selected, decrement-before starts at base-4n and decrement-after starts at base-4n+4.
- R5: With writeback on, `base_o` at done is base+4n for increment modes and base-4n for decrement modes. With writeback off, `base_o` equals the base that was given.
- R6: With `mode_i[2]`=1, bit 1 means the stack grows upward (1) or downward (0), and bit 0 means the pointer is full (1) or empty (0). For stores: full-down acts as decrement-before, empty-down as decrement-after, full-up as increment-before, and empty-up as increment-after.
- R7: For loads, the stack codes act as follows: full-down as increment-after, empty-down as increment-before, full-up as decrement-after, and empty-up as decrement-before.
- R8: A beat moves on only in a cycle where valid and ready are both high. While ready is low, valid, index, address and direction stay unchanged.
- R9: `done_o` is high for exactly the one cycle after the cycle in which the last beat is accepted. It is never high while a beat is valid.
- R10: An empty register list issues no beat. `done_o` rises in the cycle after start, and `base_o` equals the given base.
- R11: A start pulse that arrives while a transfer is still issuing beats is ignored.
- R12: After reset, `beat_valid_o` and `done_o` are low and `base_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a transfer |
| load_i | input | 1 | 1 = load from memory, 0 = store to memory |
| mode_i | input | 3 | Addressing mode code (see R3, R6, R7) |
| wb_i | input | 1 | Writeback enable for the base value |
| base_i | input | 32 | Word-aligned base address |
| rlist_i | input | 16 | Mask of registers to transfer |
| beat_valid_o | output | 1 | A beat is presented |
| beat_ready_i | input | 1 | The memory side accepts the beat |
| beat_reg_o | output | 4 | Register index of the current beat |
| beat_addr_o | output | 32 | Word address of the current beat |
| beat_load_o | output | 1 | Direction of the current beat |
| done_o | output | 1 | One-cycle completion pulse |
| base_o | output | 32 | Updated base value |

## Verification
The assertions take it that the memory side may hold ready low for any number of cycles. They also take it that the base is word-aligned, and that a new start is only accepted once the block has gone idle, so that index order and the 4-byte address step only need to hold within one transfer. The stimulus uses aligned bases and a mix of stalled and unstalled beats. Each new start is issued only after the done pulse has been seen, except in the one directed case that tests a start being ignored mid-transfer.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  // basic addressing modes: {decrement, before}
  typedef enum logic [1:0] {
    AM_INC_AFT = 2'b00,
    AM_INC_BEF = 2'b01,
    AM_DEC_AFT = 2'b10,
    AM_DEC_BEF = 2'b11
  } addr_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/lsm_mode_dec.sv
module lsm_mode_dec
  import lsm_pkg::*;
(
  input  logic       load_i,
  input  logic [2:0] mode_i,
  output addr_mode_e am_o
);
  logic dec_s;
  logic bef_s;

  always_comb begin
    if (!mode_i[2]) begin
      dec_s = mode_i[1];
      bef_s = mode_i[0];
    end else begin
      // stack code: bit1 = grows upward, bit0 = pointer on full slot
      dec_s = load_i ? mode_i[1]  : ~mode_i[1];
      bef_s = load_i ? ~mode_i[0] : mode_i[0];
    end
    am_o = addr_mode_e'({dec_s, bef_s});
  end
endmodule

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
  parameter int NREG = 16,
  localparam int CW = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] vec_i,
  output logic [CW-1:0]   cnt_o
);
  logic [CW-1:0] part [NREG+1];

  assign part[0] = '0;
  for (genvar g = 0; g < NREG; g++) begin : g_acc
    assign part[g+1] = part[g] + CW'(vec_i[g]);
  end
  assign cnt_o = part[NREG];
endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] vec_i,
  output logic [IW-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
  import lsm_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int AW     = 32,
  parameter int WBYTES = 4,
  localparam int IW = $clog2(NREG),
  localparam int CW = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            load_i,
  input  logic [2:0]      mode_i,
  input  logic            wb_i,
  input  logic [AW-1:0]   base_i,
  input  logic [NREG-1:0] rlist_i,
  output logic            beat_valid_o,
  input  logic            beat_ready_i,
  output logic [IW-1:0]   beat_reg_o,
  output logic [AW-1:0]   beat_addr_o,
  output logic            beat_load_o,
  output logic            done_o,
  output logic [AW-1:0]   base_o
);
  localparam logic [AW-1:0] STEP = AW'(WBYTES);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  seq_state_e      st_q, st_d;
  logic [NREG-1:0] rem_q, rem_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [AW-1:0]   base_q, base_d;
  logic            load_q, done_q, done_d;

  addr_mode_e      am_s;
  logic [CW-1:0]   cnt_s;
  logic [AW-1:0]   span_s;
  logic [AW-1:0]   first_s;
  logic [NREG-1:0] rem_clr_s;
  logic            accept_s, fire_s, last_s;
  logic            st_en, rem_en, addr_en, base_en, load_en;

  lsm_mode_dec i_mode_dec (
    .load_i (load_i),
    .mode_i (mode_i),
    .am_o   (am_s)
  );

  lsm_popcnt #(.NREG(NREG)) i_popcnt (
    .vec_i (rlist_i),
    .cnt_o (cnt_s)
  );

  lsm_lowbit #(.NREG(NREG)) i_lowbit (
    .vec_i (rem_q),
    .idx_o (beat_reg_o)
  );

  assign span_s    = AW'(cnt_s) * STEP;
  assign accept_s  = (st_q == ST_IDLE) && start_i;
  assign fire_s    = (st_q == ST_RUN) && beat_ready_i;
  assign rem_clr_s = rem_q & (rem_q - NREG'(1));
  assign last_s    = (rem_clr_s == '0);

  // start address of the ascending walk
  always_comb begin
    unique case (am_s)
      AM_INC_AFT: first_s = base_i;
      AM_INC_BEF: first_s = base_i + STEP;
      AM_DEC_AFT: first_s = base_i - span_s + STEP;
      default:    first_s = base_i - span_s;
    endcase
  end

  // next state
  always_comb begin
    st_d   = st_q;
    rem_d  = rem_q;
    addr_d = addr_q;
    base_d = base_q;
    done_d = 1'b0;
    if (accept_s) begin
      rem_d  = rlist_i;
      addr_d = first_s;
      if (!wb_i)        base_d = base_i;
      else if (am_s[1]) base_d = base_i - span_s;
      else              base_d = base_i + span_s;
      if (rlist_i == '0) done_d = 1'b1;
      else               st_d   = ST_RUN;
    end else if (fire_s) begin
      rem_d  = rem_clr_s;
      addr_d = addr_q + STEP;
      if (last_s) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
    end
  end

  assign st_en   = accept_s || (fire_s && last_s);
  assign rem_en  = accept_s || fire_s;
  assign addr_en = accept_s || fire_s;
  assign base_en = accept_s;
  assign load_en = accept_s;

  // registers
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      addr_q <= '0;
      base_q <= '0;
      load_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (st_en)   st_q   <= st_d;
      if (rem_en)  rem_q  <= rem_d;
      if (addr_en) addr_q <= addr_d;
      if (base_en) base_q <= base_d;
      if (load_en) load_q <= load_i;
    end
  end

  assign beat_valid_o = (st_q == ST_RUN);
  assign beat_addr_o  = addr_q;
  assign beat_load_o  = load_q;
  assign done_o       = done_q;
  assign base_o       = base_q;
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
  parameter int NREG   = 16,
  parameter int AW     = 32,
  parameter int WBYTES = 4,
  localparam int IW = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          beat_valid_o,
  input logic          beat_ready_i,
  input logic [IW-1:0] beat_reg_o,
  input logic [AW-1:0] beat_addr_o,
  input logic          beat_load_o,
  input logic          done_o
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_addr_o)
      && $stable(beat_reg_o) && $stable(beat_load_o));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o && beat_ready_i |=> !beat_valid_o
      || (beat_addr_o == $past(beat_addr_o) + AW'(WBYTES)));

  // R1
  reg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o && beat_ready_i |=> !beat_valid_o
      || (beat_reg_o > $past(beat_reg_o)));

  // R1
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o && $past(beat_valid_o) |-> $stable(beat_load_o));

  // R9
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !beat_valid_o);
endmodule

bind lsm_addr_seq lsm_seq_chk #(.NREG(NREG), .AW(AW), .WBYTES(WBYTES)) i_seq_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .beat_valid_o (beat_valid_o),
  .beat_ready_i (beat_ready_i),
  .beat_reg_o   (beat_reg_o),
  .beat_addr_o  (beat_addr_o),
  .beat_load_o  (beat_load_o),
  .done_o       (done_o)
);

// File: tb/test_lsm_addr_seq.sv
module test_lsm_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // {load, mode, wb, base, rlist, first address, final base}
  localparam int VW = 1 + 3 + 1 + 32 + 16 + 32 + 32;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 3'b000, 1'b1, 32'h0000_1000, 16'h0025, 32'h0000_1000, 32'h0000_100C},
    {1'b1, 3'b001, 1'b1, 32'h0000_2000, 16'h8001, 32'h0000_2004, 32'h0000_2008},
    {1'b0, 3'b010, 1'b1, 32'h0000_3000, 16'h00F0, 32'h0000_2FF4, 32'h0000_2FF0},
    {1'b1, 3'b011, 1'b0, 32'h0000_4000, 16'h0007, 32'h0000_3FF4, 32'h0000_4000},
    {1'b0, 3'b101, 1'b1, 32'h0000_5000, 16'h000F, 32'h0000_4FF0, 32'h0000_4FF0},
    {1'b1, 3'b101, 1'b1, 32'h0000_4FF0, 16'h000F, 32'h0000_4FF0, 32'h0000_5000},
    {1'b0, 3'b100, 1'b1, 32'h0000_6000, 16'h0003, 32'h0000_5FFC, 32'h0000_5FF8},
    {1'b1, 3'b100, 1'b1, 32'h0000_5FF8, 16'h0003, 32'h0000_5FFC, 32'h0000_6000},
    {1'b0, 3'b111, 1'b1, 32'h0000_7000, 16'h0101, 32'h0000_7004, 32'h0000_7008},
    {1'b1, 3'b111, 1'b1, 32'h0000_7008, 16'h0101, 32'h0000_7004, 32'h0000_7000},
    {1'b0, 3'b110, 1'b1, 32'h0000_8000, 16'h0010, 32'h0000_8000, 32'h0000_8004},
    {1'b1, 3'b110, 1'b1, 32'h0000_8004, 16'h0010, 32'h0000_8000, 32'h0000_8000},
    {1'b1, 3'b000, 1'b1, 32'h0000_0100, 16'hFFFF, 32'h0000_0100, 32'h0000_0140},
    {1'b0, 3'b000, 1'b1, 32'h0000_9000, 16'h0000, 32'h0000_9000, 32'h0000_9000}
  };

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        load_i;
  logic [2:0]  mode_i;
  logic        wb_i;
  logic [31:0] base_i;
  logic [15:0] rlist_i;
  logic        beat_valid_o;
  logic        beat_ready_i;
  logic [3:0]  beat_reg_o;
  logic [31:0] beat_addr_o;
  logic        beat_load_o;
  logic        done_o;
  logic [31:0] base_o;

  int n_run;
  int n_fail;

  lsm_addr_seq i_lsm_addr_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .load_i       (load_i),
    .mode_i       (mode_i),
    .wb_i         (wb_i),
    .base_i       (base_i),
    .rlist_i      (rlist_i),
    .beat_valid_o (beat_valid_o),
    .beat_ready_i (beat_ready_i),
    .beat_reg_o   (beat_reg_o),
    .beat_addr_o  (beat_addr_o),
    .beat_load_o  (beat_load_o),
    .done_o       (done_o),
    .base_o       (base_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic ld, input logic [2:0] md, input logic wbe,
                        input logic [31:0] bs, input logic [15:0] rl,
                        input logic [31:0] first, input logic [31:0] expb,
                        input bit stall);
    int k;
    logic [31:0] ea;
    string ftag;
    ftag = md[2] ? (ld ? "R7" : "R6") : (md[1] ? "R4" : "R3");
    @(negedge clk);
    load_i = ld; mode_i = md; wb_i = wbe; base_i = bs; rlist_i = rl;
    start_i = 1'b1; beat_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    k = 0;
    for (int r = 0; r < 16; r++) begin
      if (rl[r]) begin
        ea = first + 32'(4 * k);
        if (stall) begin
          chk(beat_valid_o === 1'b1, "R8", 32'(beat_valid_o), 32'd1);
          @(negedge clk);
          chk(beat_valid_o === 1'b1 && beat_reg_o == 4'(r), "R8",
              32'(beat_reg_o), 32'(r));
        end
        beat_ready_i = 1'b1;
        chk(beat_valid_o === 1'b1, "R1", 32'(beat_valid_o), 32'd1);
        chk(beat_reg_o == 4'(r), "R1", 32'(beat_reg_o), 32'(r));
        chk(beat_load_o == ld, "R1", 32'(beat_load_o), 32'(ld));
        chk(beat_addr_o == ea, (k == 0) ? ftag : "R2", beat_addr_o, ea);
        @(negedge clk);
        beat_ready_i = 1'b0;
        k++;
      end
    end
    chk(done_o === 1'b1, (rl == '0) ? "R10" : "R9", 32'(done_o), 32'd1);
    chk(beat_valid_o === 1'b0, (rl == '0) ? "R10" : "R9", 32'(beat_valid_o), 32'd0);
    chk(base_o == expb, (rl == '0) ? "R10" : "R5", base_o, expb);
    @(negedge clk);
    chk(done_o === 1'b0, "R9", 32'(done_o), 32'd0);
  endtask

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; start_i = 1'b0; load_i = 1'b0; mode_i = '0; wb_i = 1'b0;
    base_i = '0; rlist_i = '0; beat_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    // R12: held in reset
    chk(beat_valid_o === 1'b0, "R12", 32'(beat_valid_o), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(beat_valid_o === 1'b0, "R12", 32'(beat_valid_o), 32'd0);
    chk(done_o === 1'b0, "R12", 32'(done_o), 32'd0);
    chk(base_o === 32'd0, "R12", base_o, 32'd0);

    for (int v = 0; v < NV; v++) begin
      run_op(VEC[v][116], VEC[v][115:113], VEC[v][112], VEC[v][111:80],
             VEC[v][79:64], VEC[v][63:32], VEC[v][31:0], (v % 2) == 1);
    end

    // R11: start mid-transfer is ignored
    @(negedge clk);
    load_i = 1'b0; mode_i = 3'b000; wb_i = 1'b1; base_i = 32'h0000_A000;
    rlist_i = 16'h0006; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b1; rlist_i = 16'hFFFF; base_i = 32'h0; load_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(beat_reg_o == 4'd1, "R11", 32'(beat_reg_o), 32'd1);
    chk(beat_addr_o == 32'h0000_A000, "R11", beat_addr_o, 32'h0000_A000);
    chk(beat_load_o == 1'b0, "R11", 32'(beat_load_o), 32'd0);
    beat_ready_i = 1'b1;
    @(negedge clk);
    chk(beat_reg_o == 4'd2, "R11", 32'(beat_reg_o), 32'd2);
    chk(beat_addr_o == 32'h0000_A004, "R11", beat_addr_o, 32'h0000_A004);
    @(negedge clk);
    beat_ready_i = 1'b0;
    chk(done_o === 1'b1, "R11", 32'(done_o), 32'd1);
    chk(base_o == 32'h0000_A008, "R11", base_o, 32'h0000_A008);
    @(negedge clk);
    chk(beat_valid_o === 1'b0, "R11", 32'(beat_valid_o), 32'd0);

    // R10: empty list with decrement mode and writeback keeps base
    run_op(1'b1, 3'b011, 1'b1, 32'h0000_B000, 16'h0000, 32'h0, 32'h0000_B000, 1'b0);

    // R12: reset during a transfer clears outputs
    @(negedge clk);
    load_i = 1'b0; mode_i = 3'b000; wb_i = 1'b1; base_i = 32'h0000_C000;
    rlist_i = 16'h00FF; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(beat_valid_o === 1'b0, "R12", 32'(beat_valid_o), 32'd0);
    chk(base_o === 32'd0, "R12", base_o, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule